// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside the page-load controller of a byte-wide paged nonvolatile memory. It watches each accepted write strobe and its address and data byte for two fixed command sequences. The short sequence has three steps. It turns on a persistent write-protect state. While protection is on, it also grants one page write. The long sequence has six steps and turns protection off. Command bytes are flagged in the same cycle so that the load controller keeps them out of the page register. Any other byte is treated as ordinary page data.

A change to the protect state is held as pending until the load controller reports the end of the programming period. Only then does it take effect, even when no data followed the command. A level output tells the controller whether the page collected in the current load may be committed to the array. While protected, a load that lacks the unlock sequence still runs its programming period, but it commits nothing. The protect flag models nonvolatile storage. It has its own clear input and is not touched by the functional reset.

Top module: `wp_seq`

## Requirements
- R1: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, given as the first bytes of a load, arm protection. protect_o rises one cycle after prog_done_i and not earlier, even when no data byte follows.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 arm a clear. protect_o falls one cycle after the following prog_done_i.
- R3: suppress_o is high, combinationally with wr_evt_i, exactly for a byte that is the next expected step of a sequence. A byte that breaks a sequence returns the matcher to idle and is not suppressed. Command addresses written outside a sequence are not suppressed.
- R4: While protect_o is high, a load without a completed sequence holds commit_ok_o low.
- R5: While protected, commit_ok_o goes high once a sequence completes. It stays high through load_end_i and falls one cycle after prog_done_i.
- R6: A sequence is matched only from the first byte of a load. Once a data byte has been taken, or a sequence has completed, later bytes in that load are data.
- R7: load_end_i drops a partial sequence. The first byte of the next load must restart it.
- R8: Write events between load_end_i and prog_done_i are ignored: they are not suppressed and do not advance the matcher.
- R9: protect_o resets to 0 only through nv_clr_ni. It keeps its value across rst_ni.
- R10: While protect_o is low, commit_ok_o is high.
- R11: After 0xAA, 0x55, 0x80 the matcher follows only the long path. A 0xA0@0x5555 at the fourth step breaks the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async functional reset |
| nv_clr_ni | input | 1 | Active-low async clear of the nonvolatile protect flag |
| wr_evt_i | input | 1 | One-cycle write-strobe event |
| wr_addr_i | input | ADDR_W | Low address bits of the write |
| wr_data_i | input | DATA_W | Data byte of the write |
| load_end_i | input | 1 | Byte-load window expired; programming starts |
| prog_done_i | input | 1 | Programming period finished |
| protect_o | output | 1 | Persistent write-protect state |
| suppress_o | output | 1 | Current write byte is a command byte |
| commit_ok_o | output | 1 | The current page load may be committed |

## Verification
The bench uses the default 15-bit address compare with the command addresses 0x5555 and 0x2AAA. Single-bit aliases such as 0x5554 and 0x2AAB are therefore real near-misses. Directed loads cover enable without data, unlock, disable, the fourth-step branch, and aborts by load end or by an early data byte. A seeded random stream then mixes partial and complete command prefixes, stray bytes and writes during programming. A bench reference model predicts suppress, commit and protect for each of them.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  typedef enum logic [2:0] {M_IDLE, M_S1, M_S2, M_D3, M_D4, M_D5} mstate_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_SET, PEND_CLR} pend_e;
  localparam logic [7:0] K_LEAD = 8'hAA;
  localparam logic [7:0] K_ALT  = 8'h55;
  localparam logic [7:0] K_EN   = 8'hA0;
  localparam logic [7:0] K_ERA  = 8'h80;
  localparam logic [7:0] K_DIS  = 8'h20;
endpackage

// File: rtl/wp_step_match.sv
`timescale 1ns/1ps
module wp_step_match import wp_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] ADDR_B = ADDR_W'(15'h2AAA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              open_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic              done_en_o,
  output logic              done_dis_o
);
  localparam logic [DATA_W-1:0] C_LEAD = DATA_W'(K_LEAD);
  localparam logic [DATA_W-1:0] C_ALT  = DATA_W'(K_ALT);
  localparam logic [DATA_W-1:0] C_EN   = DATA_W'(K_EN);
  localparam logic [DATA_W-1:0] C_ERA  = DATA_W'(K_ERA);
  localparam logic [DATA_W-1:0] C_DIS  = DATA_W'(K_DIS);

  mstate_e state_q, nxt;
  logic    at_a, at_b;

  assign at_a = (addr_i == ADDR_A);
  assign at_b = (addr_i == ADDR_B);

  always_comb begin
    nxt        = state_q;
    hit_o      = 1'b0;
    done_en_o  = 1'b0;
    done_dis_o = 1'b0;
    if (evt_i) begin
      nxt = M_IDLE;  // any miss falls back to idle
      case (state_q)
        M_IDLE: if (open_i && at_a && data_i == C_LEAD) begin hit_o = 1'b1; nxt = M_S1; end
        M_S1:   if (at_b && data_i == C_ALT) begin hit_o = 1'b1; nxt = M_S2; end
        M_S2: begin
          if (at_a && data_i == C_EN) begin
            hit_o = 1'b1; done_en_o = 1'b1;
          end else if (at_a && data_i == C_ERA) begin
            hit_o = 1'b1; nxt = M_D3;
          end
        end
        M_D3:   if (at_a && data_i == C_LEAD) begin hit_o = 1'b1; nxt = M_D4; end
        M_D4:   if (at_b && data_i == C_ALT) begin hit_o = 1'b1; nxt = M_D5; end
        M_D5:   if (at_a && data_i == C_DIS) begin hit_o = 1'b1; done_dis_o = 1'b1; end
        default: nxt = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= M_IDLE;
    else if (abort_i) state_q <= M_IDLE;
    else              state_q <= nxt;
  end
endmodule

// File: rtl/wp_load_track.sv
`timescale 1ns/1ps
module wp_load_track import wp_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  evt_i,
  input  logic  hit_i,
  input  logic  done_en_i,
  input  logic  done_dis_i,
  input  logic  load_end_i,
  input  logic  prog_done_i,
  output logic  busy_o,
  output logic  open_o,
  output logic  unlock_o,
  output pend_e pend_o
);
  logic  busy_q, sealed_q, unlock_q;
  pend_e pend_q;
  logic  done;

  assign done = done_en_i | done_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sealed_q <= 1'b0;
      unlock_q <= 1'b0;
      pend_q   <= PEND_NONE;
    end else begin
      if (prog_done_i)     busy_q <= 1'b0;
      else if (load_end_i) busy_q <= 1'b1;

      // a data byte or a finished sequence closes matching for this load
      if (load_end_i || prog_done_i)      sealed_q <= 1'b0;
      else if (evt_i && (!hit_i || done)) sealed_q <= 1'b1;

      if (prog_done_i) unlock_q <= 1'b0;
      else if (done)   unlock_q <= 1'b1;

      if (prog_done_i)     pend_q <= PEND_NONE;
      else if (done_en_i)  pend_q <= PEND_SET;
      else if (done_dis_i) pend_q <= PEND_CLR;
    end
  end

  assign busy_o   = busy_q;
  assign open_o   = ~sealed_q;
  assign unlock_o = unlock_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/wp_nv_flag.sv
`timescale 1ns/1ps
module wp_nv_flag import wp_pkg::*; (
  input  logic  clk_i,
  input  logic  clr_ni,
  input  logic  apply_i,
  input  pend_e pend_i,
  output logic  flag_o
);
  logic flag_q;

  // cleared only by its own power-on clear, never by the functional reset
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) flag_q <= 1'b0;
    else if (apply_i) begin
      if (pend_i == PEND_SET)      flag_q <= 1'b1;
      else if (pend_i == PEND_CLR) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wp_seq.sv
`timescale 1ns/1ps
module wp_seq import wp_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] ADDR_B = ADDR_W'(15'h2AAA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nv_clr_ni,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_end_i,
  input  logic              prog_done_i,
  output logic              protect_o,
  output logic              suppress_o,
  output logic              commit_ok_o
);
  logic  busy, open, unlock, evt_live;
  logic  hit, done_en, done_dis;
  pend_e pend;

  assign evt_live = wr_evt_i & ~busy;

  wp_step_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_live),
    .open_i     (open),
    .abort_i    (load_end_i | prog_done_i),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .hit_o      (hit),
    .done_en_o  (done_en),
    .done_dis_o (done_dis)
  );

  wp_load_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_live),
    .hit_i       (hit),
    .done_en_i   (done_en),
    .done_dis_i  (done_dis),
    .load_end_i  (load_end_i),
    .prog_done_i (prog_done_i),
    .busy_o      (busy),
    .open_o      (open),
    .unlock_o    (unlock),
    .pend_o      (pend)
  );

  wp_nv_flag u_flag (
    .clk_i   (clk_i),
    .clr_ni  (nv_clr_ni),
    .apply_i (prog_done_i),
    .pend_i  (pend),
    .flag_o  (protect_o)
  );

  assign suppress_o  = hit;
  assign commit_ok_o = ~protect_o | unlock;
endmodule

// File: rtl/wp_seq_chk.sv
`timescale 1ns/1ps
module wp_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic nv_clr_ni,
  input logic wr_evt_i,
  input logic load_end_i,
  input logic prog_done_i,
  input logic protect_o,
  input logic suppress_o,
  input logic commit_ok_o,
  input logic busy_i
);
  assert_suppress_needs_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_o |-> wr_evt_i);

  assert_busy_no_suppress_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !suppress_o);

  assert_load_end_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_end_i && !prog_done_i) |=> busy_i);

  assert_protect_moves_at_end_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_clr_ni)
    !$stable(protect_o) |-> $past(prog_done_i));

  assert_unprot_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !protect_o |-> commit_ok_o);

  assert_unlock_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_clr_ni)
    prog_done_i |=> (commit_ok_o == !protect_o));
endmodule

bind wp_seq wp_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nv_clr_ni   (nv_clr_ni),
  .wr_evt_i    (wr_evt_i),
  .load_end_i  (load_end_i),
  .prog_done_i (prog_done_i),
  .protect_o   (protect_o),
  .suppress_o  (suppress_o),
  .commit_ok_o (commit_ok_o),
  .busy_i      (busy)
);

// File: tb/sim_wp_seq.sv
`timescale 1ns/1ps
module sim_wp_seq;
  localparam logic [14:0] A = 15'h5555;
  localparam logic [14:0] B = 15'h2AAA;

  logic clk = 1'b0, rst_n = 1'b0, nv_n = 1'b0;
  logic evt = 1'b0, lend = 1'b0, pdone = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic protect, suppress, commit;

  always #2.5 clk = ~clk;

  wp_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .nv_clr_ni(nv_n), .wr_evt_i(evt),
    .wr_addr_i(addr), .wr_data_i(data), .load_end_i(lend), .prog_done_i(pdone),
    .protect_o(protect), .suppress_o(suppress), .commit_ok_o(commit)
  );

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_pend = 0;
  bit m_sealed = 0, m_busy = 0, m_unlock = 0, m_prot = 0;

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // reference step: hit, next state, completion (0 none, 1 enable, 2 disable)
  function automatic void mdl_step(input logic [14:0] a, input logic [7:0] d,
                                   output bit h, output int nx, output int dn);
    h = 0; nx = 0; dn = 0;
    if (m_busy) begin nx = m_st; return; end
    case (m_st)
      0: if (!m_sealed && a == A && d == 8'hAA) begin h = 1; nx = 1; end
      1: if (a == B && d == 8'h55) begin h = 1; nx = 2; end
      2: if (a == A && d == 8'hA0) begin h = 1; dn = 1; end
         else if (a == A && d == 8'h80) begin h = 1; nx = 3; end
      3: if (a == A && d == 8'hAA) begin h = 1; nx = 4; end
      4: if (a == B && d == 8'h55) begin h = 1; nx = 5; end
      5: if (a == A && d == 8'h20) begin h = 1; dn = 2; end
      default: ;
    endcase
  endfunction

  function automatic bit exp_commit();
    return !m_prot || m_unlock;
  endfunction

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string req);
    bit h; int nx, dn;
    @(negedge clk);
    evt = 1'b1; addr = a; data = d;
    #1;
    mdl_step(a, d, h, nx, dn);
    chk(suppress, h, req, $sformatf("suppress %02h@%04h", d, a));
    @(posedge clk); #1;
    evt = 1'b0;
    if (!m_busy) begin
      m_st = nx;
      if (!h || dn != 0) m_sealed = 1;
      if (dn != 0) begin m_unlock = 1; m_pend = dn; end
    end
    chk(commit, exp_commit(), (req == "R3") ? "R5" : req, "commit after write");
  endtask

  task automatic end_load(input string req);
    @(negedge clk); lend = 1'b1;
    @(posedge clk); #1; lend = 1'b0;
    m_busy = 1; m_st = 0; m_sealed = 0;
    chk(commit, exp_commit(), req, "commit at load end");
    chk(protect, m_prot, req, "protect at load end");
  endtask

  task automatic prog_end(input string req);
    @(negedge clk); pdone = 1'b1;
    @(posedge clk); #1; pdone = 1'b0;
    m_busy = 0; m_st = 0; m_sealed = 0; m_unlock = 0;
    if (m_pend == 1) m_prot = 1;
    if (m_pend == 2) m_prot = 0;
    m_pend = 0;
    chk(protect, m_prot, req, "protect after programming");
    chk(commit, exp_commit(), req, "commit after programming");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; nv_n = 1'b1;
    @(negedge clk);
    chk(protect, 1'b0, "R9", "protect after power-on");
    chk(commit, 1'b1, "R10", "commit when unprotected");
    chk(suppress, 1'b0, "R3", "suppress idle");

    // R1: enable with no data, takes effect at end of programming only
    wr(A, 8'hAA, "R1"); wr(B, 8'h55, "R1"); wr(A, 8'hA0, "R1");
    chk(protect, 1'b0, "R1", "protect before programming end");
    end_load("R1"); prog_end("R1");
    chk(protect, 1'b1, "R1", "protect set");

    // R4: protected load without sequence
    wr(15'h0100, 8'h12, "R4"); chk(commit, 1'b0, "R4", "commit blocked");
    end_load("R4"); prog_end("R4");

    // R9: functional reset keeps the flag
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(protect, 1'b1, "R9", "protect across reset");

    // R5: unlock then data
    wr(A, 8'hAA, "R5"); wr(B, 8'h55, "R5"); wr(A, 8'hA0, "R5");
    chk(commit, 1'b1, "R5", "commit unlocked");
    wr(15'h0233, 8'h5A, "R5");
    end_load("R5"); chk(commit, 1'b1, "R5", "commit held through load end");
    prog_end("R5"); chk(commit, 1'b0, "R5", "commit relocked");

    // R6: data first, then sequence is data
    wr(15'h0010, 8'h01, "R6"); wr(A, 8'hAA, "R6"); wr(B, 8'h55, "R6"); wr(A, 8'hA0, "R6");
    chk(commit, 1'b0, "R6", "no unlock after data");
    end_load("R6"); prog_end("R6");

    // R7: partial sequence dropped by load end
    wr(A, 8'hAA, "R7"); wr(B, 8'h55, "R7"); end_load("R7"); prog_end("R7");
    wr(A, 8'hA0, "R7"); end_load("R7"); prog_end("R7");

    // R8: writes during programming ignored
    end_load("R8"); wr(A, 8'hAA, "R8"); wr(B, 8'h55, "R8"); prog_end("R8");
    wr(A, 8'hA0, "R8"); chk(commit, 1'b0, "R8", "no carried progress");
    end_load("R8"); prog_end("R8");

    // R11: fourth step must follow the long path
    wr(A, 8'hAA, "R11"); wr(B, 8'h55, "R11"); wr(A, 8'h80, "R11"); wr(A, 8'hA0, "R11");
    chk(commit, 1'b0, "R11", "broken long path");
    end_load("R11"); prog_end("R11");

    // R2: disable, with trailing data
    wr(A, 8'hAA, "R2"); wr(B, 8'h55, "R2"); wr(A, 8'h80, "R2");
    wr(A, 8'hAA, "R2"); wr(B, 8'h55, "R2"); wr(A, 8'h20, "R2");
    wr(15'h0400, 8'hC3, "R2");
    end_load("R2"); chk(protect, 1'b1, "R2", "still protected before end");
    prog_end("R2"); chk(protect, 1'b0, "R2", "protect cleared");

    // R3: near-miss and broken sequence are data
    wr(A, 8'hAA, "R3"); wr(B, 8'h77, "R3"); wr(B, 8'h55, "R3");
    end_load("R3"); prog_end("R3");
    wr(15'h5554, 8'hAA, "R3"); end_load("R3"); prog_end("R3");
    chk(commit, 1'b1, "R10", "commit unprotected");

    // random loads built from command prefixes and stray bytes
    for (int ld = 0; ld < 400; ld++) begin
      int plen, kind, nstray;
      kind = $urandom_range(0, 1);
      plen = $urandom_range(0, kind ? 6 : 3);
      for (int s = 0; s < plen; s++) begin
        logic [14:0] ca; logic [7:0] cd;
        case (s)
          0: begin ca = A; cd = 8'hAA; end
          1: begin ca = B; cd = 8'h55; end
          2: begin ca = A; cd = kind ? 8'h80 : 8'hA0; end
          3: begin ca = A; cd = 8'hAA; end
          4: begin ca = B; cd = 8'h55; end
          default: begin ca = A; cd = 8'h20; end
        endcase
        if ($urandom_range(0, 15) == 0) ca = ca ^ 15'h0001;
        wr(ca, cd, "R3");
      end
      nstray = $urandom_range(0, 3);
      for (int s = 0; s < nstray; s++)
        wr($urandom_range(0, 1) ? A : 15'($urandom), 8'($urandom), "R6");
      end_load("R7");
      if ($urandom_range(0, 3) == 0) wr(A, 8'hAA, "R8");
      prog_end("R1");
    end
    summary();
  end
endmodule